// File: doc/BRIEF.md
# Work-Item Warp Dispatcher

This block turns a two-dimensional launch into a stream of 32-lane warps. A launch gives the global range (width and height, in work-items) and the workgroup shape (width and height). The block walks the workgroups in row-major order, with x fastest. Inside each workgroup it also takes the work-items in row-major order. It packs the work-items into warps and marks each occupied lane in a lane mask. Each warp goes out on a single bus with a processor index. A warp is transferred when the indexed processor reports ready.

How a workgroup is packed depends on its item count. A power-of-two group smaller than a warp shares its warp with the groups that follow it. A 32-item group fills one warp. A larger power-of-two group spans several full warps. Any other size of at most 32 items gets a warp to itself, and the lanes it does not use stay idle.

A workgroup is bound to one processor. For the first warp of a group, the processor is chosen round-robin among the ready processors. The binding holds until the group's final warp has been taken. A single-cycle done pulse follows the last transfer of the launch.

The controller has four states:
- ST_IDLE waits for `start`, latches the launch and moves to ST_BUILD.
- ST_BUILD adds one workgroup, or one 32-item slice of a large workgroup, per cycle to the warp being built.
  - It stays in ST_BUILD while a packed warp still has room and groups remain.
  - Otherwise it moves to ST_ISSUE.
- ST_ISSUE presents the warp until it is accepted.
  - After an accepted warp it returns to ST_BUILD.
  - After the final accepted warp it moves to ST_DONE.
- ST_DONE raises `done` for one cycle and returns to ST_IDLE.

Top module: `warp_dispatch`

## Requirements
- R1: Workgroups are issued in row-major order of their origins, x fastest. `warp_group` is the linear index of the workgroup that lane 0 belongs to. `warp_x` and `warp_y` are the global coordinates of lane 0's work-item.
- R2: Every presented warp has a nonzero mask whose set bits are contiguous from bit 0. Bit i is lane i. No warp holds more than 32 work-items.
- R3: When the workgroup size S is a power of two below 32, 32/S consecutive groups share one warp, with group k at lanes k*S upward. `warp_last` is 1. The final warp of a launch may hold fewer groups.
- R4: A 32-item workgroup is issued as exactly one full warp with `warp_last` = 1.
- R5: A power-of-two workgroup larger than 32 items is issued as S/32 full warps. Lane 0 of warp k is local item 32*k, taken in row-major order inside the group. `warp_last` is 1 only on the group's final warp.
- R6: A workgroup whose size is not a power of two is issued alone in one warp. Its mask has exactly S low bits set, and `warp_last` = 1.
- R7: Every warp of one workgroup carries the same `warp_proc`.
- R8: The first warp of a workgroup is given to the first ready processor counting upward, wrapping, from the processor after the one chosen for the previous group. It is accepted in the same cycle.
- R9: While `warp_valid` is high and the warp has not been taken, the warp stays presented and `warp_x`, `warp_y`, `warp_group`, `warp_mask` and `warp_last` do not change.
- R10: `done` is high for exactly one cycle, the cycle after the last warp of the launch is accepted.
- R11: After reset, `warp_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a launch; taken only when idle |
| range_x | input | ID_W | Global range width in work-items |
| range_y | input | ID_W | Global range height in work-items |
| wg_x | input | WG_W | Workgroup width |
| wg_y | input | WG_W | Workgroup height |
| proc_ready | input | NUM_PROC | Per-processor capacity flag; bit p high means processor p takes a warp this cycle |
| warp_valid | output | 1 | A warp is presented |
| warp_proc | output | PW | Index of the destination processor |
| warp_x | output | ID_W | Global x of lane 0 |
| warp_y | output | ID_W | Global y of lane 0 |
| warp_group | output | GID_W | Linear workgroup index of lane 0 |
| warp_mask | output | 32 | Lane valid mask |
| warp_last | output | 1 | This warp completes its workgroup |
| done | output | 1 | One-cycle pulse after the final warp is taken |

## Verification
The assertions rely on five properties of each launch:
- Both range dimensions are nonzero multiples of the workgroup dimensions.
- A workgroup that is not a power-of-two size has at most 32 items.
- A workgroup wider than 32 items has a width that is a multiple of 32.
- `start` is raised only while idle.
- `proc_ready` is the only source of back-pressure.

Every launch in the stimulus meets these conditions. It covers packed power-of-two groups (including single-item groups and a partial final warp), exact 32-item groups, large groups both narrower and wider than a warp, and an odd 3x3 shape. The next launch starts only after `done` has been seen. The ready pattern changes per launch: all ready, a single processor, a rotating one-hot and a pseudo-random mix that is sometimes all-idle. This exercises binding waits and the round-robin wrap.

// File: rtl/wd_pkg.sv
package wd_pkg;
    localparam int LANES = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUILD,
        ST_ISSUE,
        ST_DONE
    } wd_state_e;
endpackage

// File: rtl/wd_rr_pick.sv
module wd_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [PW-1:0] gnt,
    output logic          any
);
    function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input int k);
        int c;
        c = int'(p) + k;
        if (c >= N) c = c - N;
        return PW'(c);
    endfunction

    always_comb begin
        gnt = ptr;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!any && req[wrap_add(ptr, k)]) begin
                any = 1'b1;
                gnt = wrap_add(ptr, k);
            end
        end
    end

    AST_GNT_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[gnt]); // R8
    AST_ANY_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        any == (req != '0)); // R8
endmodule

// File: rtl/wd_group_walker.sv
module wd_group_walker #(
    parameter int ID_W  = 12,
    parameter int WG_W  = 7,
    parameter int GID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [ID_W-1:0]  range_x,
    input  logic [ID_W-1:0]  range_y,
    input  logic [WG_W-1:0]  wg_x,
    input  logic [WG_W-1:0]  wg_y,
    output logic [ID_W-1:0]  org_x,
    output logic [ID_W-1:0]  org_y,
    output logic [GID_W-1:0] grp_id,
    output logic             is_final
);
    logic [ID_W:0] nxt_x, nxt_y;

    assign nxt_x    = {1'b0, org_x} + (ID_W+1)'(wg_x);
    assign nxt_y    = {1'b0, org_y} + (ID_W+1)'(wg_y);
    assign is_final = (nxt_x >= {1'b0, range_x}) && (nxt_y >= {1'b0, range_y});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            org_x  <= '0;
            org_y  <= '0;
            grp_id <= '0;
        end else if (load) begin
            org_x  <= '0;
            org_y  <= '0;
            grp_id <= '0;
        end else if (step) begin
            grp_id <= grp_id + 1'b1;
            if (nxt_x >= {1'b0, range_x}) begin
                org_x <= '0;
                org_y <= nxt_y[ID_W-1:0];
            end else begin
                org_x <= nxt_x[ID_W-1:0];
            end
        end
    end

    AST_WALK_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load && (nxt_x < {1'b0, range_x}) |=> $stable(org_y)); // R1
endmodule

// File: rtl/warp_dispatch.sv
module warp_dispatch
    import wd_pkg::*;
#(
    parameter int NUM_PROC = 4,
    parameter int ID_W     = 12,
    parameter int WG_W     = 7,
    parameter int GID_W    = 16,
    localparam int PW      = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ID_W-1:0]     range_x,
    input  logic [ID_W-1:0]     range_y,
    input  logic [WG_W-1:0]     wg_x,
    input  logic [WG_W-1:0]     wg_y,
    input  logic [NUM_PROC-1:0] proc_ready,
    output logic                warp_valid,
    output logic [PW-1:0]       warp_proc,
    output logic [ID_W-1:0]     warp_x,
    output logic [ID_W-1:0]     warp_y,
    output logic [GID_W-1:0]    warp_group,
    output logic [LANES-1:0]    warp_mask,
    output logic                warp_last,
    output logic                done
);
    localparam int SZ_W = 2 * WG_W;
    localparam int LW   = $clog2(LANES) + 1;
    localparam int LSH  = $clog2(LANES);

    wd_state_e state_q, state_d;

    logic [ID_W-1:0]  cfg_rx, cfg_ry;
    logic [WG_W-1:0]  cfg_wx, cfg_wy;
    logic [ID_W-1:0]  bx_q, by_q, lx_q, ly_q;
    logic [GID_W-1:0] bg_q;
    logic [LANES-1:0] mask_q;
    logic [LW-1:0]    fill_q;
    logic [SZ_W-1:0]  wcnt_q;
    logic             last_q, fin_q;
    logic             locked_q;
    logic [PW-1:0]    lock_proc_q, rr_ptr_q;

    logic [SZ_W-1:0]  grp_size, warps_per_grp;
    logic             is_big, is_pow2, grp_end;
    logic [LW-1:0]    chunk, fill_sum;
    logic [LANES-1:0] mask_next;
    logic [ID_W-1:0]  org_x, org_y;
    logic [GID_W-1:0] grp_id;
    logic             is_final, walk_load, walk_step;
    logic [PW-1:0]    arb_gnt;
    logic             arb_any, accept;

    function automatic logic [LANES-1:0] low_ones(input logic [LW-1:0] n);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (i < int'(n));
        return m;
    endfunction

    function automatic logic [LW-1:0] rows_per_warp(input logic [WG_W-1:0] w);
        logic [LW-1:0] r;
        r = LW'(1);
        for (int k = 0; k < LSH; k++)
            if (w == WG_W'(1 << k)) r = LW'(LANES >> k);
        return r;
    endfunction

    // ---------------- derived launch properties
    assign grp_size      = SZ_W'(cfg_wx) * SZ_W'(cfg_wy);
    assign is_big        = grp_size > SZ_W'(LANES);
    assign is_pow2       = (grp_size & (grp_size - 1'b1)) == '0;
    assign warps_per_grp = grp_size >> LSH;
    assign grp_end       = (wcnt_q == warps_per_grp - 1'b1);
    assign chunk         = is_big ? LW'(LANES) : LW'(grp_size);
    assign fill_sum      = fill_q + chunk;
    assign mask_next     = mask_q | (low_ones(chunk) << fill_q);

    assign walk_load = (state_q == ST_IDLE) && start;
    assign walk_step = (state_q == ST_BUILD) && (!is_big || grp_end);

    wd_group_walker #(.ID_W(ID_W), .WG_W(WG_W), .GID_W(GID_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (walk_load),
        .step     (walk_step),
        .range_x  (cfg_rx),
        .range_y  (cfg_ry),
        .wg_x     (cfg_wx),
        .wg_y     (cfg_wy),
        .org_x    (org_x),
        .org_y    (org_y),
        .grp_id   (grp_id),
        .is_final (is_final)
    );

    wd_rr_pick #(.N(NUM_PROC), .PW(PW)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (proc_ready),
        .ptr   (rr_ptr_q),
        .gnt   (arb_gnt),
        .any   (arb_any)
    );

    // ---------------- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_BUILD;
            ST_BUILD: if (is_big || !is_pow2 || fill_sum == LW'(LANES) || is_final)
                          state_d = ST_ISSUE;
            ST_ISSUE: if (accept) state_d = fin_q ? ST_DONE : ST_BUILD;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs
    always_comb begin
        warp_valid = (state_q == ST_ISSUE);
        warp_proc  = locked_q ? lock_proc_q : arb_gnt;
        accept     = warp_valid && (locked_q ? proc_ready[lock_proc_q] : arb_any);
        warp_x     = bx_q;
        warp_y     = by_q;
        warp_group = bg_q;
        warp_mask  = mask_q;
        warp_last  = last_q;
        done       = (state_q == ST_DONE);
    end

    // ---------------- datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rx <= '0; cfg_ry <= '0; cfg_wx <= '0; cfg_wy <= '0;
            bx_q <= '0; by_q <= '0; bg_q <= '0; lx_q <= '0; ly_q <= '0;
            mask_q <= '0; fill_q <= '0; wcnt_q <= '0;
            last_q <= 1'b0; fin_q <= 1'b0;
            locked_q <= 1'b0; lock_proc_q <= '0; rr_ptr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cfg_rx <= range_x; cfg_ry <= range_y;
                    cfg_wx <= wg_x;    cfg_wy <= wg_y;
                    mask_q <= '0; fill_q <= '0; wcnt_q <= '0;
                    lx_q <= '0; ly_q <= '0; locked_q <= 1'b0;
                end
                ST_BUILD: begin
                    if (fill_q == '0) begin
                        bx_q <= org_x + (is_big ? lx_q : '0);
                        by_q <= org_y + (is_big ? ly_q : '0);
                        bg_q <= grp_id;
                    end
                    mask_q <= mask_next;
                    fill_q <= fill_sum;
                    if (is_big) begin
                        last_q <= grp_end;
                        fin_q  <= grp_end && is_final;
                        if (grp_end) begin
                            wcnt_q <= '0; lx_q <= '0; ly_q <= '0;
                        end else begin
                            wcnt_q <= wcnt_q + 1'b1;
                            if (cfg_wx >= WG_W'(LANES)) begin
                                if (lx_q + ID_W'(LANES) == ID_W'(cfg_wx)) begin
                                    lx_q <= '0;
                                    ly_q <= ly_q + 1'b1;
                                end else begin
                                    lx_q <= lx_q + ID_W'(LANES);
                                end
                            end else begin
                                ly_q <= ly_q + ID_W'(rows_per_warp(cfg_wx));
                            end
                        end
                    end else begin
                        last_q <= 1'b1;
                        fin_q  <= is_final;
                    end
                end
                ST_ISSUE: if (accept) begin
                    mask_q <= '0;
                    fill_q <= '0;
                    if (!locked_q)
                        rr_ptr_q <= (warp_proc == PW'(NUM_PROC - 1)) ? '0 : warp_proc + 1'b1;
                    locked_q    <= !last_q;
                    lock_proc_q <= warp_proc;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // ---------------- assertion support: binding seen at the bus
    logic          chk_open;
    logic [PW-1:0] chk_proc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_open <= 1'b0;
            chk_proc <= '0;
        end else if (accept) begin
            chk_open <= !warp_last;
            chk_proc <= warp_proc;
        end
    end

    AST_MASK_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid |-> (warp_mask != '0) && (((warp_mask + 1'b1) & warp_mask) == '0)); // R2
    AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid && !accept |=> warp_valid && $stable(warp_x) && $stable(warp_y)
            && $stable(warp_group) && $stable(warp_mask) && $stable(warp_last)); // R9
    AST_GROUP_SAME_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid && chk_open |-> warp_proc == chk_proc); // R7
    AST_ODD_GROUP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid && !is_pow2 |-> warp_last && ($countones(warp_mask) == int'(grp_size))); // R6
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(accept)); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_NO_WARP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !warp_valid); // R10
endmodule

// File: tb/tb_warp_dispatch.sv
module tb_warp_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] range_x = '0, range_y = '0;
    logic [6:0]  wg_x = '0, wg_y = '0;
    logic [NP-1:0] proc_ready = '0;
    logic        warp_valid;
    logic [1:0]  warp_proc;
    logic [11:0] warp_x, warp_y;
    logic [15:0] warp_group;
    logic [31:0] warp_mask;
    logic        warp_last;
    logic        done;

    warp_dispatch dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .range_x(range_x), .range_y(range_y), .wg_x(wg_x), .wg_y(wg_y),
        .proc_ready(proc_ready), .warp_valid(warp_valid), .warp_proc(warp_proc),
        .warp_x(warp_x), .warp_y(warp_y), .warp_group(warp_group),
        .warp_mask(warp_mask), .warp_last(warp_last), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int x; int y; int g; logic [31:0] m; bit last;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0, cycles = 0;
    int m_ptr = 0, m_lproc = 0;
    bit m_lock = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ones(input int n);
        logic [63:0] v;
        v = (64'd1 << n) - 64'd1;
        return v[31:0];
    endfunction

    function automatic void plan(input int rx, input int ry, input int wx, input int wy);
        int s, ngx, ntot, p;
        exp_t e;
        s = wx * wy; ngx = rx / wx; ntot = ngx * (ry / wy);
        q.delete();
        if (s > 32) begin
            for (int g = 0; g < ntot; g++)
                for (int w = 0; w < s / 32; w++) begin
                    e.x = (g % ngx) * wx + (32 * w) % wx;
                    e.y = (g / ngx) * wy + (32 * w) / wx;
                    e.g = g; e.m = 32'hFFFF_FFFF; e.last = (w == s / 32 - 1);
                    q.push_back(e);
                end
        end else if ((s & (s - 1)) == 0) begin
            p = 32 / s;
            for (int g = 0; g < ntot; g += p) begin
                int n;
                n = (ntot - g < p) ? ntot - g : p;
                e.x = (g % ngx) * wx; e.y = (g / ngx) * wy; e.g = g;
                e.m = ones(n * s); e.last = 1;
                q.push_back(e);
            end
        end else begin
            for (int g = 0; g < ntot; g++) begin
                e.x = (g % ngx) * wx; e.y = (g / ngx) * wy; e.g = g;
                e.m = ones(s); e.last = 1;
                q.push_back(e);
            end
        end
    endfunction

    function automatic int first_ready(input int ptr, input logic [NP-1:0] r);
        for (int k = 0; k < NP; k++)
            if (r[(ptr + k) % NP]) return (ptr + k) % NP;
        return -1;
    endfunction

    task automatic launch(input int rx, input int ry, input int wx, input int wy,
                          input int mode, input string tag);
        bit exp_done, seen_done;
        int n;
        plan(rx, ry, wx, wy);
        @(negedge clk);
        range_x = 12'(rx); range_y = 12'(ry); wg_x = 7'(wx); wg_y = 7'(wy);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_done = 0; seen_done = 0; n = 0;
        m_lock = 0;
        while (!seen_done && n < 3000) begin
            bit nxt_done;
            nxt_done = 0;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: proc_ready = '1;
                1: proc_ready = lfsr[3:0] & lfsr[7:4];
                2: proc_ready = 4'b0100;
                default: proc_ready = 4'(1 << (n % NP));
            endcase
            #1;
            check(done == exp_done, "R10", "done", done, exp_done);
            if (done) seen_done = 1;
            if (warp_valid) begin
                if (q.size() == 0) begin
                    check(0, "R1", "unexpected warp", warp_group, -1);
                end else begin
                    int ep;
                    bit acc;
                    check(int'(warp_x) == q[0].x, tag, "warp_x", warp_x, q[0].x);
                    check(int'(warp_y) == q[0].y, tag, "warp_y", warp_y, q[0].y);
                    check(int'(warp_group) == q[0].g, tag, "warp_group", warp_group, q[0].g);
                    check(warp_mask == q[0].m, tag, "warp_mask", warp_mask, q[0].m);
                    check(warp_last == q[0].last, tag, "warp_last", warp_last, q[0].last);
                    if (m_lock) begin
                        ep = m_lproc;
                        check(int'(warp_proc) == ep, "R7", "bound proc", warp_proc, ep);
                        acc = proc_ready[ep];
                    end else begin
                        ep = first_ready(m_ptr, proc_ready);
                        acc = (ep >= 0);
                        if (acc)
                            check(int'(warp_proc) == ep, "R8", "round-robin pick", warp_proc, ep);
                    end
                    if (acc) begin
                        if (!m_lock) m_ptr = (ep + 1) % NP;
                        m_lock = !q[0].last;
                        m_lproc = ep;
                        void'(q.pop_front());
                        if (q.size() == 0) nxt_done = 1;
                    end
                end
            end
            exp_done = nxt_done;
            n++;
            @(negedge clk);
        end
        check(seen_done && q.size() == 0, "R10", "launch completion (remaining warps)", q.size(), 0);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                check(0, "R10", "watchdog expired", cycles, 0);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(warp_valid == 1'b0, "R11", "warp_valid in reset", warp_valid, 0);
        check(done == 1'b0, "R11", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(warp_valid == 1'b0, "R11", "warp_valid after reset", warp_valid, 0);
        check(done == 1'b0, "R11", "done after reset", done, 0);

        launch(16, 8, 4, 2, 0, "R1 R3");      // 8-item groups, four per warp
        launch(8, 8, 4, 2, 1, "R1 R3");       // packing across group rows
        launch(6, 4, 2, 2, 3, "R2 R3");       // partial final warp, 24 lanes
        launch(5, 3, 1, 1, 1, "R2 R3");       // single-item groups, 15 lanes
        launch(32, 4, 8, 4, 2, "R1 R4");      // exact 32-item groups
        launch(16, 16, 8, 8, 1, "R5");        // 64-item groups, 4 rows per warp
        launch(128, 2, 64, 1, 3, "R5");       // groups wider than a warp
        launch(9, 6, 3, 3, 1, "R6");          // odd size, idle lanes
        launch(12, 4, 3, 2, 0, "R6");         // 6-item groups
        launch(16, 16, 16, 4, 1, "R1 R5");    // mixed binding under random ready

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule